// File: doc/BRIEF.md
# DMA Transfer Address Engine

This block carries out a single DMA transfer each time it sees a start pulse. It has three modes. In copy mode it reads a value at the source and writes it to the destination. In immediate mode it writes a value supplied with the start pulse to the destination. In sum mode it reads one operand at the source and a second at the destination, adds them and writes the result back to the destination. Each transfer moves either one byte or one halfword. The block keeps a 32-bit source address register and a 32-bit destination address register. When the block is idle these registers are loaded through a load pulse. After a transfer, each register either stays where it is or steps forward, under separate control for each.

The usable address space has two parts: the bottom 32 MB (00000000h to 01FFFFFFh) and the top 32 MB (FE000000h to FFFFFFFFh). Stepping past the top of the lower part leaves 02000000h in the register, and the bus access for that value is sent to FE000000h. Stepping past FFFFFFFFh wraps the register to zero. A halfword access at FFFFFFFFh is followed by a second access of the same kind at 00000000h. Sum-mode destinations are confined to the lowest 64 KB of the bus.

A controller FSM sequences the transfer. Its states are IDLE, RD_SRC, RD_SRC_DUP, RD_DST, WR_DST, WR_DST_DUP and FINISH. The transitions are:
- IDLE to WR_DST on start in immediate mode.
- IDLE to RD_SRC on start in the other modes.
- RD_SRC to RD_SRC_DUP when a halfword read hits the top address.
- RD_SRC or RD_SRC_DUP to RD_DST in sum mode, otherwise to WR_DST.
- RD_DST to WR_DST.
- WR_DST to WR_DST_DUP when a halfword write hits the top address outside sum mode, otherwise to FINISH.
- WR_DST_DUP to FINISH.
- FINISH to IDLE, stepping the address registers.

Every state except IDLE and FINISH leaves only when `mem_ready` is accepted.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and both address registers read zero. A `load` pulse while idle copies `load_src` and `load_dst` into the source and destination registers.
- R2: In copy mode (`mode`=00, and also 11), the block reads at the source bus address and then writes the data it read to the destination bus address.
- R3: In immediate mode (`mode`=01), the block makes no read and writes `imm_data` to the destination bus address.
- R4: In sum mode (`mode`=10), the block reads the source, then reads the destination, then writes (source + destination) modulo 2^8 or 2^16 to the destination.
- R5: `wide`=0 selects byte transfers. The write data then has bits 15:8 at zero, `mem_wide` is low and a stepping register advances by 1. `wide`=1 selects halfword transfers, and a stepping register advances by 2.
- R6: `src_inc` and `dst_inc` choose independently whether each register steps after the transfer. In immediate mode the source register never steps.
- R7: Stepping past FFFFFFFFh wraps the register to 00000000h.
- R8: A register value with bits 31:25 equal to 0000001b is issued on the bus with those bits set to 1111111b. For example, register 02000000h gives bus address FE000000h.
- R9: A halfword write whose bus address is FFFFFFFFh, outside sum mode, is followed by a write of the same data at 00000000h.
- R10: A halfword source read at bus address FFFFFFFFh is followed by a read at 00000000h. The transfer uses the data from the first read.
- R11: In sum mode, the destination bus address is the destination register's bits 15:0 with bits 31:16 at zero.
- R12: Once raised, `mem_req` stays high with a stable address, direction and write data until `mem_ready` is high at a clock edge.
- R13: `busy` is high from the cycle after start until the cycle in which `done` is high. `done` is high for exactly one cycle. After it, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load address registers (idle only) |
| load_src | input | 32 | Source address to load |
| load_dst | input | 32 | Destination address to load |
| start | input | 1 | Begin one transfer (idle only) |
| mode | input | 2 | 00/11 copy, 01 immediate, 10 sum |
| wide | input | 1 | 1 halfword, 0 byte |
| src_inc | input | 1 | Step source register after transfer |
| dst_inc | input | 1 | Step destination register after transfer |
| imm_data | input | 16 | Immediate value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | Access size, 1 halfword |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted at this edge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_addr | output | 32 | Source address register |
| dst_addr | output | 32 | Destination address register |

## Verification
The assertions take three things for granted about the inputs. `mem_rdata` is meaningful only in a cycle where `mem_ready` meets a request. `start` and `load` are given only while `busy` is low. Loaded addresses lie in the valid space or in the single remapped word just above the lower part, and halfword addresses are even except for the top address. The stimulus keeps to these rules: it raises `start` or `load` only after the previous transfer has finished, and it loads only such addresses. The memory model holds ready low on a fixed pattern of cycles, so that requests have to wait.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
    localparam int AW = 32;
    localparam int DW = 16;

    typedef enum logic [1:0] {
        MD_COPY = 2'b00,
        MD_IMM  = 2'b01,
        MD_SUM  = 2'b10,
        MD_ALT  = 2'b11
    } xfer_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_SRC_DUP,
        ST_RD_DST,
        ST_WR_DST,
        ST_WR_DST_DUP,
        ST_FINISH
    } xfer_state_t;
endpackage

// File: rtl/dxe_addr_unit.sv
module dxe_addr_unit #(
    parameter int AW      = 32,
    parameter int LO_BITS = 25,
    parameter int WIN_BITS = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          wide,
    input  logic          step_en,
    input  logic          low_win,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] bus,
    output logic          top_hit
);
    localparam int HI_BITS = AW - LO_BITS;
    localparam logic [HI_BITS-1:0] GAP_TAG = HI_BITS'(1);

    always_comb begin
        if (low_win)
            bus = {{(AW-WIN_BITS){1'b0}}, cur[WIN_BITS-1:0]};
        else if (cur[AW-1:LO_BITS] == GAP_TAG)
            bus = {{HI_BITS{1'b1}}, cur[LO_BITS-1:0]};
        else
            bus = cur;
        top_hit = wide && !low_win && (bus == {AW{1'b1}});
        nxt     = step_en ? cur + (wide ? AW'(2) : AW'(1)) : cur;
    end
endmodule

// File: rtl/dxe_sum.sv
module dxe_sum #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          wide,
    output logic [DW-1:0] y
);
    localparam int HW = DW / 2;
    logic [DW-1:0] full;
    always_comb begin
        full = a + b;
        y    = wide ? full : {{(DW-HW){1'b0}}, full[HW-1:0]};
    end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dxe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_src,
    input  logic [ADDR_W-1:0] load_dst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              wide,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic [DATA_W-1:0] imm_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int HW = DATA_W / 2;

    xfer_state_t       state, state_nx;
    xfer_mode_t        mode_q;
    logic              wide_q, sinc_q, dinc_q;
    logic [DATA_W-1:0] op_a, op_b, sum_y, rd_val;
    logic [ADDR_W-1:0] src_q, dst_q, src_nx, dst_nx, src_bus, dst_bus;
    logic              src_top, dst_top, accept, is_sum, src_step;

    assign is_sum   = (mode_q == MD_SUM);
    assign src_step = sinc_q && (mode_q != MD_IMM);
    assign accept   = mem_req && mem_ready;
    assign rd_val   = wide_q ? mem_rdata : {{(DATA_W-HW){1'b0}}, mem_rdata[HW-1:0]};

    dxe_addr_unit #(.AW(ADDR_W)) u_src_addr (
        .cur(src_q), .wide(wide_q), .step_en(src_step), .low_win(1'b0),
        .nxt(src_nx), .bus(src_bus), .top_hit(src_top)
    );

    dxe_addr_unit #(.AW(ADDR_W)) u_dst_addr (
        .cur(dst_q), .wide(wide_q), .step_en(dinc_q), .low_win(is_sum),
        .nxt(dst_nx), .bus(dst_bus), .top_hit(dst_top)
    );

    dxe_sum #(.DW(DATA_W)) u_sum (
        .a(op_a), .b(op_b), .wide(wide_q), .y(sum_y)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start) state_nx = (xfer_mode_t'(mode) == MD_IMM) ? ST_WR_DST : ST_RD_SRC;
            ST_RD_SRC:     if (accept) state_nx = src_top ? ST_RD_SRC_DUP : (is_sum ? ST_RD_DST : ST_WR_DST);
            ST_RD_SRC_DUP: if (accept) state_nx = is_sum ? ST_RD_DST : ST_WR_DST;
            ST_RD_DST:     if (accept) state_nx = ST_WR_DST;
            ST_WR_DST:     if (accept) state_nx = dst_top ? ST_WR_DST_DUP : ST_FINISH;
            ST_WR_DST_DUP: if (accept) state_nx = ST_FINISH;
            ST_FINISH:     state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wide  = wide_q;
        mem_wdata = '0;
        busy      = (state != ST_IDLE);
        done      = 1'b0;
        unique case (state)
            ST_IDLE:       begin mem_wide = 1'b0; end
            ST_RD_SRC:     begin mem_req = 1'b1; mem_addr = src_bus; end
            ST_RD_SRC_DUP: begin mem_req = 1'b1; mem_addr = '0; end
            ST_RD_DST:     begin mem_req = 1'b1; mem_addr = dst_bus; end
            ST_WR_DST:     begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst_bus;
                                 mem_wdata = is_sum ? sum_y : op_a; end
            ST_WR_DST_DUP: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = '0;
                                 mem_wdata = op_a; end
            ST_FINISH:     begin done = 1'b1; end
            default:       begin busy = 1'b0; end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            op_a   <= '0;
            op_b   <= '0;
            mode_q <= MD_COPY;
            wide_q <= 1'b0;
            sinc_q <= 1'b0;
            dinc_q <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                if (load) begin
                    src_q <= load_src;
                    dst_q <= load_dst;
                end
                if (start) begin
                    mode_q <= xfer_mode_t'(mode);
                    wide_q <= wide;
                    sinc_q <= src_inc;
                    dinc_q <= dst_inc;
                    op_a   <= wide ? imm_data : {{(DATA_W-HW){1'b0}}, imm_data[HW-1:0]};
                end
            end
            if (state == ST_RD_SRC && accept) op_a <= rd_val;
            if (state == ST_RD_DST && accept) op_b <= rd_val;
            if (state == ST_FINISH) begin
                src_q <= src_nx;
                dst_q <= dst_nx;
            end
        end
    end

    assign src_addr = src_q;
    assign dst_addr = dst_q;

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8
    bus_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ADDR_W-1:25] == '0 || mem_addr[ADDR_W-1:25] == '1));

    // R11
    sum_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && is_sum) |-> (mem_addr[ADDR_W-1:16] == '0));

    // R9
    dup_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mem_we && mem_wide && !is_sum && mem_addr == '1)
        |=> (mem_req && mem_we && mem_addr == '0 && $stable(mem_wdata)));

    // R5
    byte_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_wide) |-> (mem_wdata[DATA_W-1:HW] == '0));
endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [15:0] data;
        bit          wide;
        string       tag;
    } acc_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        load = 0, start = 0, wide = 0, src_inc = 0, dst_inc = 0;
    logic [31:0] load_src = 0, load_dst = 0;
    logic [1:0]  mode = 0;
    logic [15:0] imm_data = 0;
    logic        mem_req, mem_we, mem_wide, busy, done;
    logic [31:0] mem_addr, src_addr, dst_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 0;
    logic        mem_ready = 0;

    int errors = 0, checks = 0, cyc = 0, pat = 0;
    acc_t exp_q[$];
    logic [31:0] m_src = 0, m_dst = 0;

    always #2.5 clk = ~clk;

    dma_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_src(load_src), .load_dst(load_dst),
        .start(start), .mode(mode), .wide(wide), .src_inc(src_inc), .dst_inc(dst_inc),
        .imm_data(imm_data), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    function automatic logic [15:0] mem_val(input logic [31:0] a);
        return a[15:0] ^ a[31:16] ^ 16'h5A3C;
    endfunction

    function automatic logic [31:0] bus_of(input logic [31:0] r, input bit win);
        if (win) return {16'h0, r[15:0]};
        if (r[31:25] == 7'h01) return {7'h7F, r[24:0]};
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        acc_t e;
        cyc++;
        pat++;
        mem_ready = mem_req && (pat % 3 != 0);
        mem_rdata = mem_val(mem_addr);
        if (mem_req && mem_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected access", mem_addr, 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(mem_we == e.we && mem_addr == e.addr && mem_wide == e.wide &&
                      (!e.we || mem_wdata == e.data),
                      e.tag, {mem_addr[31:1], mem_we}, {e.addr[31:1], e.we});
                if (e.we && mem_wdata != e.data)
                    $display("     data actual=%h expected=%h", mem_wdata, e.data);
            end
        end
        if (cyc > 20000) begin
            check(1'b0, "watchdog", cyc, 20000);
            finish_run();
        end
    end

    task automatic push(input bit we, input logic [31:0] a, input logic [15:0] d, input bit w, input string tag);
        acc_t e;
        e.we = we; e.addr = a; e.data = d; e.wide = w; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_load(input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        load = 1; load_src = s; load_dst = d;
        @(negedge clk);
        load = 0;
        m_src = s; m_dst = d;
        check(src_addr == s && dst_addr == d, "R1 load", src_addr ^ dst_addr, s ^ d);
    endtask

    task automatic run(input logic [1:0] md, input bit w, input bit si, input bit di,
                       input logic [15:0] imm, input string tag);
        logic [31:0] sb, db;
        logic [15:0] va, vb, res, msk;
        bit sum_md, imm_md;
        sum_md = (md == 2'b10);
        imm_md = (md == 2'b01);
        msk = w ? 16'hFFFF : 16'h00FF;
        sb = bus_of(m_src, 1'b0);
        db = bus_of(m_dst, sum_md);
        va = imm & msk;
        if (!imm_md) begin
            push(0, sb, 0, w, tag);
            va = mem_val(sb) & msk;
            if (w && sb == 32'hFFFFFFFF) push(0, 32'h0, 0, w, {tag, " R10 dup read"});
        end
        res = va;
        if (sum_md) begin
            push(0, db, 0, w, tag);
            vb = mem_val(db) & msk;
            res = (va + vb) & msk;
        end
        push(1, db, res, w, tag);
        if (w && !sum_md && db == 32'hFFFFFFFF) push(1, 32'h0, res, w, {tag, " R9 dup write"});
        if (si && !imm_md) m_src = m_src + (w ? 2 : 1);
        if (di) m_dst = m_dst + (w ? 2 : 1);

        @(negedge clk);
        mode = md; wide = w; src_inc = si; dst_inc = di; imm_data = imm; start = 1;
        @(negedge clk);
        start = 0;
        check(busy == 1'b1, {tag, " R13 busy"}, busy, 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        // R13: one-cycle done, busy falls
        check(!done && !busy, {tag, " R13 done pulse"}, {done, busy}, 0);
        check(src_addr == m_src, {tag, " R6 src reg"}, src_addr, m_src);
        check(dst_addr == m_dst, {tag, " R6 dst reg"}, dst_addr, m_dst);
        check(exp_q.size() == 0, {tag, " all accesses seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !mem_req, "R1 reset outputs", {busy, done, mem_req}, 0);
        check(src_addr == 0 && dst_addr == 0, "R1 reset regs", src_addr | dst_addr, 0);
        rst_n = 1;
        @(negedge clk);

        do_load(32'h0000_0100, 32'h0000_2000);
        run(2'b00, 1, 1, 1, 0, "R2 copy wide");
        run(2'b00, 1, 1, 1, 0, "R2 copy wide step");
        run(2'b11, 0, 0, 1, 0, "R5 copy byte src fixed");
        run(2'b00, 0, 1, 0, 0, "R6 copy byte dst fixed");
        run(2'b01, 1, 1, 1, 16'hBEEF, "R3 imm wide");
        run(2'b01, 0, 0, 1, 16'hBEEF, "R3 R5 imm byte");

        do_load(32'h0000_0400, 32'hFE00_1234);
        run(2'b10, 1, 1, 1, 0, "R4 R11 sum wide");
        run(2'b10, 0, 0, 0, 0, "R4 sum byte");

        do_load(32'h0000_0010, 32'hFFFF_FFFE);
        run(2'b01, 0, 0, 1, 16'h0011, "R7 byte at top-1");
        run(2'b01, 0, 0, 1, 16'h0022, "R7 byte wrap");
        do_load(32'h0000_0010, 32'hFFFF_FFFF);
        run(2'b01, 1, 0, 1, 16'hA55A, "R9 halfword top");
        check(dst_addr == 32'h1, "R7 wrap after halfword", dst_addr, 1);

        do_load(32'h0000_0010, 32'h01FF_FFFF);
        run(2'b01, 0, 0, 1, 16'h0033, "R8 last low byte");
        check(dst_addr == 32'h0200_0000, "R8 gap value", dst_addr, 32'h0200_0000);
        run(2'b01, 1, 0, 1, 16'h4444, "R8 remapped write");

        do_load(32'hFFFF_FFFF, 32'h0000_3000);
        run(2'b00, 1, 1, 1, 0, "R10 copy from top");

        finish_run();
    end
endmodule